// File: doc/BRIEF.md
# Serial DAC Command Word Transmitter

This block is the host-side master for a three-wire serial DAC. It takes one command at a time over a valid/ready handshake. A command is a 2-bit operating mode and a 14-bit output code. The block packs them into a 16-bit word and sends that word MSB first. It drives a frame select (`ser_sync_n`, active low), a serial clock (`ser_clk`) and a data line (`ser_data`). The serial clock idles low. Data moves on the rising edge of the serial clock and is sampled by the receiver on the falling edge. All timing is built from the system clock, and the parameters set every interval in system cycles. At elaboration the block checks those parameters against the receiver's limits: clock period at least 33 ns, each clock phase at least 5 ns, frame select at least 10 ns ahead of the first falling edge, and a frame-select high time of at least 20 ns.

A command can be sent in two ways. In the continuous way, all 16 bits go out as one burst. In the byte-split way, chosen per command by `cmd_split`, the word goes out as two bursts of eight clock pulses. Between the two bursts there is a quiet pause, and the frame select stays low through it. After the 16th falling edge the frame select goes high, and a one-cycle `frame_done` pulse marks that cycle. The frame select then stays high for a minimum gap before the next command can be taken.

The controller is a state machine with six states. IDLE waits for a command. LEAD holds the frame select low before the first clock pulse. HIGH is the high phase of a clock pulse and LOW is the low phase. PAUSE is the gap between the two bytes in byte-split mode. GAP is the frame-select-high interval after a frame.

The transitions are:
- IDLE→LEAD on acceptance.
- LEAD→HIGH when the lead time expires.
- HIGH→LOW at each falling edge.
- LOW→HIGH for the next bit.
- LOW→PAUSE after the eighth bit of a byte-split word.
- PAUSE→HIGH when the pause ends.
- LOW→GAP after the sixteenth bit.
- GAP→IDLE when the gap expires.

Top module: `dac_frame_tx`

## Requirements
- R1: While reset is applied and just after it is released, `ser_sync_n` is 1, `ser_clk` is 0, `frame_done` is 0 and `cmd_ready` is 1.
- R2: Each frame carries 16 bits MSB first. Word bit 15 is `cmd_mode[1]`, bit 14 is `cmd_mode[0]`, and bits 13:0 are `cmd_code[13:0]`. The receiver sees exactly 16 falling edges of `ser_clk` while `ser_sync_n` is low.
- R3: `ser_clk` is 0 whenever `ser_sync_n` is high. Within a frame, `ser_data` changes only in the cycle in which `ser_clk` rises, so it is stable across every falling edge.
- R4: The first falling edge of `ser_clk` comes exactly LEAD_CYC + DIV_HALF system cycles after `ser_sync_n` falls.
- R5: Each high phase of `ser_clk` lasts DIV_HALF system cycles. Each low phase between bits also lasts DIV_HALF cycles, except the phase at the byte boundary in byte-split mode.
- R6: `ser_sync_n` rises only after the 16th falling edge. `frame_done` is high for exactly the one cycle in which `ser_sync_n` rises.
- R7: Between frames `ser_sync_n` stays high for at least GAP_CYC + 1 system cycles. When the next command is already waiting, the high time is exactly GAP_CYC + 1 cycles.
- R8: `cmd_ready` is 0 from the cycle after acceptance until the gap after the frame ends. Values on `cmd_mode`, `cmd_code`, `cmd_split` and `cmd_valid` while `cmd_ready` is 0 do not change the frame in flight.
- R9: With `cmd_split` = 1 at acceptance, the low phase after the 8th falling edge lasts DIV_HALF + PAUSE_CYC cycles with `ser_sync_n` held low. The received word is still intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The transmitter can accept a command this cycle |
| cmd_mode | input | 2 | Operating-mode field, sent in word bits 15:14 |
| cmd_code | input | 14 | Output code, sent in word bits 13:0 |
| cmd_split | input | 1 | 1 sends the word as two 8-pulse bursts |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_sync_n | output | 1 | Frame select, active low |
| ser_data | output | 1 | Serial data, changes on the rising edge of `ser_clk` |
| frame_done | output | 1 | One-cycle pulse when `ser_sync_n` rises |

## Verification
The two functions that can fall in the same cycle are the end of the post-frame gap and the acceptance of a new command. This happens when `cmd_valid` is held high across a whole frame. The bench provokes it with back-to-back commands. While the first frame is in flight, it holds `cmd_valid` high and puts scrambled values on the data inputs, then presents the next real command well before the gap ends. It judges the case in three ways: the measured frame-select high time must be exactly GAP_CYC + 1 cycles, both words must arrive intact at a falling-edge receiver model, and the `frame_done` pulse must land on the frame-select rise and not on the acceptance.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    localparam int MODE_W     = 2;
    localparam int CODE_W     = 14;
    localparam int FRAME_BITS = MODE_W + CODE_W;
    localparam int SPLIT_AT   = FRAME_BITS / 2;
    localparam int BCNT_W     = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_LEAD  = 3'd1,
        S_HIGH  = 3'd2,
        S_LOW   = 3'd3,
        S_PAUSE = 3'd4,
        S_GAP   = 3'd5
    } tx_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_tx_timer.sv
module dac_tx_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/dac_tx_shreg.sv
module dac_tx_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);

    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= din;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[W-1];

endmodule

// File: rtl/dac_tx_fsm.sv
module dac_tx_fsm
    import dac_tx_pkg::*;
#(
    parameter int TW        = 4,
    parameter int DIV_HALF  = 2,
    parameter int LEAD_CYC  = 1,
    parameter int PAUSE_CYC = 4,
    parameter int GAP_CYC   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_split,
    output logic          cmd_ready,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          sh_load,
    output logic          sh_shift,
    output logic          ser_clk,
    output logic          ser_sync_n,
    output logic          frame_done
);

    localparam logic [TW-1:0]     T_LEAD  = TW'(LEAD_CYC - 1);
    localparam logic [TW-1:0]     T_HALF  = TW'(DIV_HALF - 1);
    localparam logic [TW-1:0]     T_PAUSE = TW'(PAUSE_CYC - 1);
    localparam logic [TW-1:0]     T_GAP   = TW'(GAP_CYC - 1);
    localparam logic [BCNT_W-1:0] N_LAST  = BCNT_W'(FRAME_BITS);
    localparam logic [BCNT_W-1:0] N_SPLIT = BCNT_W'(SPLIT_AT);

    tx_state_e         state_q, state_d;
    logic [BCNT_W-1:0] bit_cnt_q;
    logic              split_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer/shifter control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    state_d  = S_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = T_LEAD;
                    sh_load  = 1'b1;
                end
            end
            S_LEAD: begin
                if (tmr_zero) begin
                    state_d  = S_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = T_HALF;
                end
            end
            S_HIGH: begin
                if (tmr_zero) begin
                    state_d  = S_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = T_HALF;
                end
            end
            S_LOW: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (bit_cnt_q == N_LAST) begin
                        state_d = S_GAP;
                        tmr_val = T_GAP;
                    end else if (split_q && (bit_cnt_q == N_SPLIT)) begin
                        state_d = S_PAUSE;
                        tmr_val = T_PAUSE;
                    end else begin
                        state_d  = S_HIGH;
                        tmr_val  = T_HALF;
                        sh_shift = 1'b1;
                    end
                end
            end
            S_PAUSE: begin
                if (tmr_zero) begin
                    state_d  = S_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = T_HALF;
                    sh_shift = 1'b1;
                end
            end
            S_GAP: begin
                if (tmr_zero) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Falling-edge count and byte-split selection captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            split_q   <= 1'b0;
        end else if (state_q == S_IDLE && cmd_valid) begin
            bit_cnt_q <= '0;
            split_q   <= cmd_split;
        end else if (state_q == S_HIGH && tmr_zero) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // Registered Moore outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_clk    <= 1'b0;
            ser_sync_n <= 1'b1;
            frame_done <= 1'b0;
        end else begin
            ser_clk    <= (state_d == S_HIGH);
            ser_sync_n <= (state_d == S_IDLE) || (state_d == S_GAP);
            frame_done <= (state_q == S_LOW) && (state_d == S_GAP);
        end
    end

    assign cmd_ready = (state_q == S_IDLE);

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sync_n |-> !ser_clk);

    p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_sync_n) |-> (bit_cnt_q == N_LAST));

    p_done_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $rose(ser_sync_n));

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_sync_n |-> !cmd_ready);

    p_split_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PAUSE) |-> (split_q && (bit_cnt_q == N_SPLIT)));

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
    import dac_tx_pkg::*;
#(
    parameter int CLK_PS    = 10000,
    parameter int DIV_HALF  = 2,
    parameter int LEAD_CYC  = 1,
    parameter int PAUSE_CYC = 4,
    parameter int GAP_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [MODE_W-1:0] cmd_mode,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              cmd_split,
    output logic              ser_clk,
    output logic              ser_sync_n,
    output logic              ser_data,
    output logic              frame_done
);

    localparam int MAX_CYC = imax(imax(DIV_HALF, LEAD_CYC), imax(PAUSE_CYC, GAP_CYC));
    localparam int TW      = $clog2(MAX_CYC + 1);

    // Receiver timing limits, in picoseconds
    localparam int MIN_PERIOD_PS = 33000;
    localparam int MIN_PHASE_PS  = 5000;
    localparam int MIN_SETUP_PS  = 10000;
    localparam int MIN_GAP_PS    = 20000;

    if (DIV_HALF < 1 || LEAD_CYC < 1 || PAUSE_CYC < 1 || GAP_CYC < 1) begin : g_bad_zero
        $error("dac_frame_tx: all interval parameters must be at least 1");
    end
    if (DIV_HALF * CLK_PS < MIN_PHASE_PS) begin : g_bad_phase
        $error("dac_frame_tx: serial clock phase too short");
    end
    if (2 * DIV_HALF * CLK_PS < MIN_PERIOD_PS) begin : g_bad_period
        $error("dac_frame_tx: serial clock period too short");
    end
    if ((LEAD_CYC + DIV_HALF) * CLK_PS < MIN_SETUP_PS) begin : g_bad_setup
        $error("dac_frame_tx: frame select setup too short");
    end
    if (GAP_CYC * CLK_PS < MIN_GAP_PS) begin : g_bad_gap
        $error("dac_frame_tx: frame select high time too short");
    end

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          sh_load;
    logic          sh_shift;

    dac_tx_fsm #(
        .TW        (TW),
        .DIV_HALF  (DIV_HALF),
        .LEAD_CYC  (LEAD_CYC),
        .PAUSE_CYC (PAUSE_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_split  (cmd_split),
        .cmd_ready  (cmd_ready),
        .tmr_zero   (tmr_zero),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .sh_load    (sh_load),
        .sh_shift   (sh_shift),
        .ser_clk    (ser_clk),
        .ser_sync_n (ser_sync_n),
        .frame_done (frame_done)
    );

    dac_tx_timer #(
        .TW (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    dac_tx_shreg #(
        .W (FRAME_BITS)
    ) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .shift (sh_shift),
        .din   ({cmd_mode, cmd_code}),
        .msb   (ser_data)
    );

    p_data_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_sync_n && !$past(ser_sync_n) && (ser_data != $past(ser_data)))
            |-> $rose(ser_clk));

endmodule

// File: tb/dac_frame_tx_tb.sv
module dac_frame_tx_tb;

    localparam int DIV_HALF  = 2;
    localparam int LEAD_CYC  = 1;
    localparam int PAUSE_CYC = 4;
    localparam int GAP_CYC   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_mode = '0;
    logic [13:0] cmd_code = '0;
    logic        cmd_split = 1'b0;
    logic        ser_clk, ser_sync_n, ser_data, frame_done;

    always #5 clk = ~clk;

    dac_frame_tx #(
        .CLK_PS    (10000),
        .DIV_HALF  (DIV_HALF),
        .LEAD_CYC  (LEAD_CYC),
        .PAUSE_CYC (PAUSE_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_mode   (cmd_mode),
        .cmd_code   (cmd_code),
        .cmd_split  (cmd_split),
        .ser_clk    (ser_clk),
        .ser_sync_n (ser_sync_n),
        .ser_data   (ser_data),
        .frame_done (frame_done)
    );

    typedef struct packed {
        logic [15:0] word;
        logic        split;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   b2b = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Driver: call at a negedge; leaves cmd_valid high with scrambled data
    task automatic send(input logic [1:0] m, input logic [13:0] c, input logic s);
        cmd_valid = 1'b1;
        cmd_mode  = m;
        cmd_code  = c;
        cmd_split = s;
        while (!cmd_ready) @(negedge clk);
        exp_q.push_back({m, c, s});
        @(negedge clk);
        cmd_mode  = ~m;
        cmd_code  = ~c;
        cmd_split = ~s;
    endtask

    task automatic wait_idle();
        do @(negedge clk);
        while (!(cmd_ready && ser_sync_n && exp_q.size() == 0));
    endtask

    task automatic single(input logic [1:0] m, input logic [13:0] c, input logic s);
        send(m, c, s);
        cmd_valid = 1'b0;
        wait_idle();
    endtask

    // Monitor with falling-edge receiver model
    bit          p_sync = 1'b1;
    bit          p_sclk = 1'b0;
    bit          p_sdo = 1'b0;
    bit          seen_frame = 1'b0;
    int          t_run = 0;
    int          t_since = 0;
    int          fe = 0;
    int          gap = 0;
    int          cyc = 0;
    logic [15:0] rx = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit cur_split;
            cur_split = (exp_q.size() > 0) ? exp_q[0].split : 1'b0;
            cyc++;
            if (cyc > 100000) begin
                chk(1'b0, "R2", "watchdog expired", cyc, 100000);
                finish_run();
            end
            if (frame_done && !(!p_sync && ser_sync_n))
                chk(1'b0, "R6", "done pulse away from frame-select rise", 1, 0);

            if (p_sync && !ser_sync_n) begin
                chk(ser_clk == 1'b0, "R3", "clock level at frame start", ser_clk, 0);
                if (seen_frame) begin
                    chk(gap >= GAP_CYC + 1, "R7", "frame-select high time", gap, GAP_CYC + 1);
                    if (b2b)
                        chk(gap == GAP_CYC + 1, "R7", "back-to-back high time", gap, GAP_CYC + 1);
                end
                t_run   = 1;
                t_since = 1;
                fe      = 0;
                rx      = '0;
            end else if (!p_sync && !ser_sync_n) begin
                chk(!cmd_ready, "R8", "ready during frame", cmd_ready, 0);
                if (p_sclk && !ser_clk) begin
                    chk(t_run == DIV_HALF, "R5", "high phase length", t_run, DIV_HALF);
                    chk(ser_data == p_sdo, "R3", "data moved at falling edge", ser_data, p_sdo);
                    if (fe == 0)
                        chk(t_since == LEAD_CYC + DIV_HALF, "R4", "select to first fall",
                            t_since, LEAD_CYC + DIV_HALF);
                    fe++;
                    rx    = {rx[14:0], ser_data};
                    t_run = 1;
                end else if (!p_sclk && ser_clk) begin
                    if (fe == 0)
                        chk(t_run == LEAD_CYC, "R4", "lead length", t_run, LEAD_CYC);
                    else if (cur_split && fe == 8)
                        chk(t_run == DIV_HALF + PAUSE_CYC, "R9", "byte pause low time",
                            t_run, DIV_HALF + PAUSE_CYC);
                    else
                        chk(t_run == DIV_HALF, "R5", "low phase length", t_run, DIV_HALF);
                    t_run = 1;
                end else begin
                    t_run++;
                    if (ser_data != p_sdo)
                        chk(1'b0, "R3", "data moved without rising clock", ser_data, p_sdo);
                end
                t_since++;
            end else if (!p_sync && ser_sync_n) begin
                exp_t e;
                chk(fe == 16, "R6", "falling edges in frame", fe, 16);
                chk(frame_done == 1'b1, "R6", "done at frame-select rise", frame_done, 1);
                chk(!cmd_ready, "R8", "ready at frame end", cmd_ready, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "frame with nothing expected", rx, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rx == e.word, e.split ? "R9" : "R2", "received word",
                        int'(rx), int'(e.word));
                end
                gap        = 1;
                seen_frame = 1'b1;
            end else begin
                if (seen_frame) begin
                    gap++;
                    if (gap <= GAP_CYC)
                        chk(!cmd_ready, "R8", "ready inside gap", cmd_ready, 0);
                end
                chk(ser_clk == 1'b0, "R3", "clock idle while deselected", ser_clk, 0);
            end
            p_sync = ser_sync_n;
            p_sclk = ser_clk;
            p_sdo  = ser_data;
        end
    end

    initial begin
        logic [31:0] v;
        v = 32'h1234_5678;
        @(negedge clk);
        chk(ser_sync_n == 1'b1, "R1", "select in reset", ser_sync_n, 1);
        chk(ser_clk == 1'b0, "R1", "clock in reset", ser_clk, 0);
        chk(frame_done == 1'b0, "R1", "done in reset", frame_done, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
        chk(ser_sync_n == 1'b1, "R1", "select after reset", ser_sync_n, 1);

        // R2 continuous frames at the code extremes
        single(2'b00, 14'h0000, 1'b0);
        single(2'b11, 14'h3FFF, 1'b0);
        single(2'b01, 14'h2000, 1'b0);
        // R9 byte-split frames
        single(2'b01, 14'h2AAA, 1'b1);
        single(2'b10, 14'h1555, 1'b1);

        // R7 R8 back-to-back with scrambled inputs while busy
        b2b = 1'b1;
        send(2'b10, 14'h0F0F, 1'b0);
        repeat (10) @(negedge clk);
        send(2'b01, 14'h30C3, 1'b1);
        repeat (10) @(negedge clk);
        send(2'b11, 14'h0001, 1'b0);
        cmd_valid = 1'b0;
        wait_idle();
        b2b = 1'b0;

        for (int i = 0; i < 16; i++) begin
            v = v * 32'd1103515245 + 32'd12345;
            single(v[31:30], v[20:7], v[3]);
        end

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "words left unsent", exp_q.size(), 0);
        finish_run();
    end

endmodule